// File: doc/BRIEF.md
# LCD Blink and Frame Update Controller

This block sits between a processor's register writes and an LCD segment driver. The processor writes segment words into a shadow store. On each frame-start tick the controller copies the whole shadow store into the active display buffer, unless the processor has raised a hold bit. While hold is high, the processor can rewrite the shadow words freely and the panel keeps showing the old picture. A sticky status flag reports that fresh data was taken in at a frame start.

The controller also decides whether the display is lit. A two-bit mode selects one of four behaviours: software off, software on, a fixed 2 Hz blink, or a blink whose rate comes from a two-bit rate field. Blink timing counts an 8 Hz reference tick. The on/off decision is applied only at frame starts, so a frame is never partly blanked. An optional polarity flip inverts the drive on alternate frames.

Top module: `lcd_blink_ctrl`

## Requirements
- R1: After reset, `seg_out`, `disp_on`, `polarity` and `upd_flag` are all 0. The blink phase starts in the on state.
- R2: A write (`wr_en`) updates shadow word `wr_addr`, which occupies bits `[wr_addr*DW +: DW]` of `seg_out`. `seg_out` changes only on the clock edge that follows a cycle in which `frame_tick` is high and `hold` is low. It then takes the shadow contents as they were before any write in that same cycle.
- R3: While `hold` is high, `frame_tick` leaves `seg_out` unchanged.
- R4: The edge after a copy (`frame_tick` high with `hold` low) sets `upd_flag`. The set takes priority over any clear in the same cycle.
- R5: `upd_flag` clears on the edge after `flag_clr` is high. It also clears on the edge after the first cycle of a rising `hold`.
- R6: At a frame tick, `blink_mode` 00 turns `disp_on` off and mode 01 turns it on.
- R7: In mode 10 the blink phase toggles every 2 `ref_tick` pulses, giving 2 Hz from an 8 Hz tick. The first half of each period is on.
- R8: In mode 11 the phase toggles every 4×(N) `ref_tick` pulses, where `blink_rate` values 00, 01, 10 and 11 give N = 1, 2, 3 and 4. This yields 1, 1/2, 1/3 and 1/4 Hz.
- R9: Any change of `blink_mode` or `blink_rate` restarts the blink count and puts the phase in the on state. This takes priority over a `ref_tick` in the same cycle.
- R10: `disp_on` changes only on the edge after a `frame_tick`. In modes 10 and 11 it then takes the blink phase as it stood before that edge.
- R11: With `inv_en` high, `polarity` toggles on the edge after each `frame_tick`. With `inv_en` low, `polarity` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle pulse at each frame start |
| ref_tick | input | 1 | One-cycle pulse at 8 Hz |
| wr_en | input | 1 | Shadow word write strobe |
| wr_addr | input | AW | Shadow word index |
| wr_data | input | DW | Shadow word data |
| hold | input | 1 | Freeze active data at frame starts |
| blink_mode | input | 2 | Display/blink mode |
| blink_rate | input | 2 | Blink rate used in mode 11 |
| inv_en | input | 1 | Alternate-frame polarity flip enable |
| flag_clr | input | 1 | Write-one clear of the update flag |
| seg_out | output | NW*DW | Active segment data |
| disp_on | output | 1 | Display lit |
| polarity | output | 1 | Drive polarity, 1 means inverted |
| upd_flag | output | 1 | Fresh data taken in at a frame start |

## Verification
The hardest cases to reach from the ports are collisions within one cycle. One is a frame tick that coincides with a flag clear or with a shadow write. Another is a configuration change that coincides with a reference tick. A further case is a slow-rate blink reaching its half-period without a mode change resetting it first. The stimulus draws ticks, writes, clears and hold toggles from a seeded `$urandom`, each with its own probability. Mode changes are rare, so long blink periods still complete. Directed steps force each collision, and a bench model predicts every output on every cycle.

// File: rtl/lcd_blink_ctrl.sv
module lcd_blink_ctrl #(
  parameter int NW = 4,
  parameter int DW = 8,
  parameter int FAST_HALF = 2,
  parameter int SLOW_UNIT = 4,
  localparam int AW = (NW > 1) ? $clog2(NW) : 1,
  localparam int CW = $clog2(SLOW_UNIT * 4 + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_tick,
  input  logic             ref_tick,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             hold,
  input  logic [1:0]       blink_mode,
  input  logic [1:0]       blink_rate,
  input  logic             inv_en,
  input  logic             flag_clr,
  output logic [NW*DW-1:0] seg_out,
  output logic             disp_on,
  output logic             polarity,
  output logic             upd_flag
);

  logic [NW*DW-1:0] shadow;
  logic [3:0]       cfg_q;
  logic             hold_q;
  logic [CW-1:0]    cnt;
  logic             phase;
  logic [CW-1:0]    half;

  wire take    = frame_tick && !hold;
  wire cfg_chg = {blink_mode, blink_rate} != cfg_q;
  wire wrap    = cnt >= half - CW'(1);

  assign half = (blink_mode == 2'b10) ? CW'(FAST_HALF)
                                      : CW'(SLOW_UNIT) * (CW'(blink_rate) + CW'(1));

  for (genvar i = 0; i < NW; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                                 shadow[i*DW +: DW] <= '0;
      else if (wr_en && wr_addr == AW'(i))        shadow[i*DW +: DW] <= wr_data;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)     seg_out[i*DW +: DW] <= '0;
      else if (take)  seg_out[i*DW +: DW] <= shadow[i*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      cfg_q  <= {blink_mode, blink_rate};
      hold_q <= hold;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) upd_flag <= 1'b0;
    else if (take) upd_flag <= 1'b1;
    else if (flag_clr || (hold && !hold_q)) upd_flag <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b1;
    end else if (cfg_chg) begin
      cnt   <= '0;
      phase <= 1'b1;
    end else if (ref_tick) begin
      if (wrap) begin
        cnt   <= '0;
        phase <= !phase;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) disp_on <= 1'b0;
    else if (frame_tick)
      case (blink_mode)
        2'b00:   disp_on <= 1'b0;
        2'b01:   disp_on <= 1'b1;
        default: disp_on <= phase;
      endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) polarity <= 1'b0;
    else if (frame_tick && inv_en) polarity <= !polarity;

endmodule

module lcd_blink_ctrl_chk #(
  parameter int NW = 4,
  parameter int DW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_tick,
  input logic             hold,
  input logic [1:0]       blink_mode,
  input logic             inv_en,
  input logic             flag_clr,
  input logic [NW*DW-1:0] seg_out,
  input logic             disp_on,
  input logic             polarity,
  input logic             upd_flag
);
  AST_SEG_ONLY_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(seg_out)); // R2
  AST_SEG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && hold) |=> $stable(seg_out)); // R3
  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && !hold) |=> upd_flag); // R4
  AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !(frame_tick && !hold)) |=> !upd_flag); // R5
  AST_MODE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && blink_mode == 2'b00) |=> !disp_on); // R6
  AST_MODE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && blink_mode == 2'b01) |=> disp_on); // R6
  AST_DISP_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(disp_on)); // R10
  AST_POL_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && inv_en) |=> polarity != $past(polarity)); // R11
  AST_POL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_tick && inv_en) |=> $stable(polarity)); // R11
endmodule

bind lcd_blink_ctrl lcd_blink_ctrl_chk #(.NW(NW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .hold(hold),
  .blink_mode(blink_mode), .inv_en(inv_en), .flag_clr(flag_clr),
  .seg_out(seg_out), .disp_on(disp_on), .polarity(polarity), .upd_flag(upd_flag)
);

// File: tb/lcd_blink_ctrl_tb.sv
module lcd_blink_ctrl_tb;
  localparam int NW = 4, DW = 8, AW = 2;

  logic clk = 0, rst_n = 0;
  logic frame_tick = 0, ref_tick = 0, wr_en = 0, hold = 0, inv_en = 0, flag_clr = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0] blink_mode = 0, blink_rate = 0;
  logic [NW*DW-1:0] seg_out;
  logic disp_on, polarity, upd_flag;

  int checks = 0, errors = 0;

  // expected-state model
  logic [NW*DW-1:0] m_shadow = '0, m_seg = '0;
  logic m_disp = 0, m_pol = 0, m_flag = 0, m_ph = 1, m_hold_q = 0;
  logic [3:0] m_cfg = '0;
  int m_cnt = 0;

  always #2 clk = ~clk;

  lcd_blink_ctrl #(.NW(NW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .ref_tick(ref_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .hold(hold),
    .blink_mode(blink_mode), .blink_rate(blink_rate), .inv_en(inv_en),
    .flag_clr(flag_clr), .seg_out(seg_out), .disp_on(disp_on),
    .polarity(polarity), .upd_flag(upd_flag));

  function automatic int half_of(input logic [1:0] md, input logic [1:0] rt);
    return (md == 2'b10) ? 2 : 4 * (int'(rt) + 1); // R7 R8
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2/R3 seg_out", 64'(seg_out), 64'(m_seg));
    chk("R6/R7/R8/R10 disp_on", 64'(disp_on), 64'(m_disp));
    chk("R11 polarity", 64'(polarity), 64'(m_pol));
    chk("R4/R5 upd_flag", 64'(upd_flag), 64'(m_flag));
  endtask

  task automatic step();
    logic take, chg;
    @(posedge clk);
    #1;
    take = frame_tick && !hold;
    chg = {blink_mode, blink_rate} != m_cfg;
    if (take) m_seg = m_shadow;
    if (wr_en) m_shadow[wr_addr*DW +: DW] = wr_data;
    if (take) m_flag = 1;
    else if (flag_clr || (hold && !m_hold_q)) m_flag = 0;
    if (frame_tick) m_disp = (blink_mode == 0) ? 1'b0 : (blink_mode == 1) ? 1'b1 : m_ph;
    if (frame_tick && inv_en) m_pol = !m_pol;
    if (chg) begin m_cnt = 0; m_ph = 1; end // R9
    else if (ref_tick) begin
      if (m_cnt >= half_of(blink_mode, blink_rate) - 1) begin m_cnt = 0; m_ph = !m_ph; end
      else m_cnt++;
    end
    m_cfg = {blink_mode, blink_rate};
    m_hold_q = hold;
    compare_all();
  endtask

  task automatic idle();
    frame_tick = 0; ref_tick = 0; wr_en = 0; flag_clr = 0;
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1));
    #9;
    compare_all(); // R1 reset state
    rst_n = 1;
    step();

    // R2: write then frame copy; R4 set wins over simultaneous clear
    wr_en = 1; wr_addr = 2; wr_data = 8'hA5; step();
    idle(); step();
    chk("R2 no copy before frame", 64'(seg_out), 64'h0);
    frame_tick = 1; flag_clr = 1; wr_en = 1; wr_addr = 0; wr_data = 8'h3C; step();
    idle();
    chk("R4 set beats clear", 64'(upd_flag), 64'd1);
    chk("R2 copied word", 64'(seg_out[2*DW +: DW]), 64'hA5);
    chk("R2 same-cycle write not copied", 64'(seg_out[7:0]), 64'h0);
    // R5 clear by rising hold; R3 held frame
    hold = 1; step();
    chk("R5 cleared by hold rise", 64'(upd_flag), 64'd0);
    wr_en = 1; wr_addr = 1; wr_data = 8'h77; step();
    idle(); frame_tick = 1; step();
    idle();
    chk("R3 held frame", 64'(seg_out[DW +: DW]), 64'h0);
    hold = 0; frame_tick = 1; step(); idle();
    flag_clr = 1; step(); idle();
    chk("R5 cleared by write-one", 64'(upd_flag), 64'd0);

    // R7: mode 10, change coincides with ref tick (R9)
    blink_mode = 2'b10; ref_tick = 1; step();
    for (int k = 0; k < 40; k++) begin
      ref_tick = (k % 3 == 0); frame_tick = (k % 2 == 0); step();
    end
    idle();
    // R8 R9: each rate
    for (int r = 0; r < 4; r++) begin
      blink_mode = 2'b11; blink_rate = 2'(r); ref_tick = 1; step();
      for (int k = 0; k < 80; k++) begin
        ref_tick = (k % 2 == 0); frame_tick = (k % 3 == 0); step();
      end
      idle();
    end
    // R6 R11 software modes and inversion
    inv_en = 1; blink_mode = 2'b00; frame_tick = 1; step();
    blink_mode = 2'b01; step(); inv_en = 0; step(); idle(); step();

    // constrained random
    for (int n = 0; n < 20000; n++) begin
      frame_tick = ($urandom % 5) == 0;
      ref_tick   = ($urandom % 3) == 0;
      wr_en      = ($urandom % 4) == 0;
      wr_addr    = AW'($urandom);
      wr_data    = DW'($urandom);
      flag_clr   = ($urandom % 9) == 0;
      if (($urandom % 40) == 0) hold = ~hold;
      if (($urandom % 60) == 0) inv_en = ~inv_en;
      if (($urandom % 400) == 0) begin blink_mode = 2'($urandom); blink_rate = 2'($urandom); end
      step();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule